// File: doc/BRIEF.md
# PCI Target Forwarding and Retry Controller

This block makes the target-side decision for a bridge between a PCI bus and a 32-bit backplane bus. At each address phase it looks at the command, the address, IDSEL, and the per-slot enable mask. From these it decides one of three outcomes:

- Claim the transaction and forward it downstream.
- Service it locally as a configuration access.
- Ignore it.

Writes into enabled slot space are posted. They complete on PCI at once, and a forward request with the unchanged address, byte enables and word limit goes to the downstream master.

Reads cannot be posted. A read is terminated with Retry until the downstream side can serve it. The first attempt that finds the downstream side idle and owned launches one fetch and latches the request. A later repeat of that exact request completes once the fetched data is ready.

During a claimed memory burst, a beat counter signals disconnect on the last data word allowed. That limit is two words for ordinary commands and one full cache line for cache-line commands.

Top module: `pci_fwd_target`

## Requirements
- R1: I/O commands (0010 read, 0011 write) are never claimed, retried or forwarded, whatever their address.
- R2: A memory command (0110, 0111, 1100, 1110, 1111) hits only when addr[31:28] = 0xF and bit addr[27:24] of `slot_en` is set. Any other memory address gives no claim, no retry and no forward request.
- R3: A configuration command (1010 read, 1011 write) with `idsel` high and addr[1:0] = 00 is claimed with `cfg_strobe` and is not forwarded. Any other configuration access is ignored.
- R4: A memory write hit is claimed and forwarded with `fwd_write` = 1, unless `dn_busy` is high or a read request is latched. In either of those cases it is retried and not forwarded.
- R5: A memory read hit that does not complete a latched request is retried. If `dn_busy` is high or `dn_owned` is low, no forward request is made.
- R6: A memory read hit made while idle, owned and with no latched request is retried, issues one forward request with `fwd_write` = 0, and latches its address and command.
- R7: A read that repeats the latched address and command while `dn_rdata_ready` is high is claimed and clears the latch. A different read while a request is latched is retried without a forward request.
- R8: The burst limit, which is also reported on `fwd_words`, depends on the command. Ordinary memory commands get 2 words. For cache-line commands (1100, 1110, 1111) the limit comes from `cls_code`: 00 gives 4, 01 gives 8, 10 gives 16, and 11 gives 2. After a memory claim, `tgt_disc` is high while the current beat is the last allowed one.
- R9: `fwd_addr` and `fwd_be` equal the address and byte enables of the request, unchanged.
- R10: After reset all response strobes, `tgt_disc` and the read latch are clear. Responses appear one clock after `addr_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr_valid | input | 1 | Address phase strobe |
| cmd | input | 4 | PCI command code |
| addr | input | 32 | Address |
| be | input | 4 | Byte enables |
| idsel | input | 1 | Configuration select |
| slot_en | input | 16 | Per-slot forwarding enable |
| cls_code | input | 2 | Cache line size code |
| dn_busy | input | 1 | Downstream command still pending |
| dn_owned | input | 1 | Backplane bus owned |
| dn_rdata_ready | input | 1 | Fetched read data available |
| data_beat | input | 1 | One data word transferred |
| tgt_claim | output | 1 | Transaction claimed (pulse) |
| tgt_retry | output | 1 | Terminate with Retry (pulse) |
| tgt_disc | output | 1 | Current beat is the last allowed |
| cfg_strobe | output | 1 | Local configuration access (pulse) |
| fwd_req | output | 1 | Downstream request (pulse) |
| fwd_write | output | 1 | Forwarded request is a write |
| fwd_addr | output | 32 | Forwarded address |
| fwd_be | output | 4 | Forwarded byte enables |
| fwd_words | output | 5 | Word limit of forwarded request |

## Verification
A table drives single address phases that differ in one dimension each:

- enabled slot, disabled slot and non-slot addresses, which separate the slot decode from the top-nibble check;
- memory, I/O and configuration commands, with and without IDSEL and type-0 encoding;
- busy and unowned downstream states, which separate retry from claim.

Directed sequences then walk the read latch through launch, mismatched repeat, early repeat and completing repeat. Further sequences count beats to the disconnect for each cache line code against the two-word ordinary limit.

// File: rtl/pci_fwd_pkg.sv
package pci_fwd_pkg;
   localparam logic [3:0] CMD_IO_RD   = 4'b0010;
   localparam logic [3:0] CMD_IO_WR   = 4'b0011;
   localparam logic [3:0] CMD_MEM_RD  = 4'b0110;
   localparam logic [3:0] CMD_MEM_WR  = 4'b0111;
   localparam logic [3:0] CMD_CFG_RD  = 4'b1010;
   localparam logic [3:0] CMD_CFG_WR  = 4'b1011;
   localparam logic [3:0] CMD_RD_MULT = 4'b1100;
   localparam logic [3:0] CMD_RD_LINE = 4'b1110;
   localparam logic [3:0] CMD_WR_INV  = 4'b1111;

   typedef struct packed {
      logic mem;
      logic wr;
      logic line;
      logic mem_hit;
      logic cfg_hit;
   } dec_t;
endpackage

// File: rtl/pci_fwd_decode.sv
module pci_fwd_decode
   import pci_fwd_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int SLOT_BITS = 4
) (
   input  logic [3:0]             cmd,
   input  logic [ADDR_W-1:0]      addr,
   input  logic                   idsel,
   input  logic [(1<<SLOT_BITS)-1:0] slot_en,
   output dec_t                   dec
);
   localparam int NSLOT = 1 << SLOT_BITS;
   localparam int SEL_LO = ADDR_W - 4 - SLOT_BITS;

   if (ADDR_W < SLOT_BITS + 6) begin : g_bad_width
      $error("pci_fwd_decode: ADDR_W too small for slot decode");
   end

   logic [NSLOT-1:0] slot_hit;
   logic             top_ok;

   assign top_ok = (addr[ADDR_W-1 -: 4] == 4'hF);

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign slot_hit[s] = slot_en[s] &&
                           (addr[SEL_LO +: SLOT_BITS] == SLOT_BITS'(s));
   end

   always_comb begin
      dec = '0;
      unique case (cmd)
         CMD_MEM_RD:  dec.mem = 1'b1;
         CMD_MEM_WR:  begin dec.mem = 1'b1; dec.wr = 1'b1; end
         CMD_RD_MULT,
         CMD_RD_LINE: begin dec.mem = 1'b1; dec.line = 1'b1; end
         CMD_WR_INV:  begin dec.mem = 1'b1; dec.wr = 1'b1; dec.line = 1'b1; end
         CMD_CFG_RD:  dec.cfg_hit = idsel && (addr[1:0] == 2'b00);
         CMD_CFG_WR:  begin
            dec.wr = 1'b1;
            dec.cfg_hit = idsel && (addr[1:0] == 2'b00);
         end
         default: ;
      endcase
      dec.mem_hit = dec.mem && top_ok && (|slot_hit);
   end
endmodule

// File: rtl/pci_fwd_limit.sv
module pci_fwd_limit #(
   parameter int MAX_LINE = 16,
   parameter int ORD_BURST = 2,
   parameter int WORD_W = $clog2(MAX_LINE + 1)
) (
   input  logic [1:0]        cls_code,
   input  logic              line_cmd,
   output logic [WORD_W-1:0] lim
);
   if (MAX_LINE < 16 || ORD_BURST < 1 || ORD_BURST > MAX_LINE) begin : g_bad_lim
      $error("pci_fwd_limit: MAX_LINE must hold 16 words and exceed ORD_BURST");
   end

   always_comb begin
      lim = WORD_W'(ORD_BURST);
      if (line_cmd) begin
         unique case (cls_code)
            2'b00:   lim = WORD_W'(4);
            2'b01:   lim = WORD_W'(8);
            2'b10:   lim = WORD_W'(16);
            default: lim = WORD_W'(ORD_BURST);
         endcase
      end
   end
endmodule

// File: rtl/pci_fwd_burst.sv
module pci_fwd_burst #(
   parameter int WORD_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] lim_in,
   input  logic              data_beat,
   output logic              disc
);
   logic              active;
   logic [WORD_W-1:0] cnt;
   logic [WORD_W-1:0] lim;

   assign disc = active && (cnt == lim - WORD_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
         lim    <= '0;
      end else if (start) begin
         active <= 1'b1;
         cnt    <= '0;
         lim    <= lim_in;
      end else if (active && data_beat) begin
         if (disc) active <= 1'b0;
         else      cnt    <= cnt + WORD_W'(1);
      end
   end

   AST_DISC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (cnt < lim)); // R8
endmodule

// File: rtl/pci_fwd_target.sv
module pci_fwd_target
   import pci_fwd_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int SLOT_BITS = 4,
   parameter int MAX_LINE  = 16,
   parameter int ORD_BURST = 2,
   parameter int WORD_W    = $clog2(MAX_LINE + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      addr_valid,
   input  logic [3:0]                cmd,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [3:0]                be,
   input  logic                      idsel,
   input  logic [(1<<SLOT_BITS)-1:0] slot_en,
   input  logic [1:0]                cls_code,
   input  logic                      dn_busy,
   input  logic                      dn_owned,
   input  logic                      dn_rdata_ready,
   input  logic                      data_beat,
   output logic                      tgt_claim,
   output logic                      tgt_retry,
   output logic                      tgt_disc,
   output logic                      cfg_strobe,
   output logic                      fwd_req,
   output logic                      fwd_write,
   output logic [ADDR_W-1:0]         fwd_addr,
   output logic [3:0]                fwd_be,
   output logic [WORD_W-1:0]         fwd_words
);
   dec_t              dec;
   logic [WORD_W-1:0] lim;
   logic              lat_valid;
   logic [ADDR_W-1:0] lat_addr;
   logic [3:0]        lat_cmd;
   logic              rd_match;
   logic              n_claim, n_retry, n_cfg, n_fwd, n_latch, n_clear;
   logic              mem_claim_q;

   pci_fwd_decode #(.ADDR_W(ADDR_W), .SLOT_BITS(SLOT_BITS)) u_dec (
      .cmd(cmd), .addr(addr), .idsel(idsel), .slot_en(slot_en), .dec(dec));

   pci_fwd_limit #(.MAX_LINE(MAX_LINE), .ORD_BURST(ORD_BURST), .WORD_W(WORD_W)) u_lim (
      .cls_code(cls_code), .line_cmd(dec.line), .lim(lim));

   pci_fwd_burst #(.WORD_W(WORD_W)) u_burst (
      .clk(clk), .rst_n(rst_n), .start(mem_claim_q), .lim_in(fwd_words),
      .data_beat(data_beat), .disc(tgt_disc));

   assign rd_match = lat_valid && (lat_addr == addr) && (lat_cmd == cmd);

   always_comb begin
      n_claim = 1'b0; n_retry = 1'b0; n_cfg = 1'b0;
      n_fwd = 1'b0; n_latch = 1'b0; n_clear = 1'b0;
      if (addr_valid) begin
         if (dec.cfg_hit) begin
            n_claim = 1'b1;
            n_cfg   = 1'b1;
         end else if (dec.mem_hit) begin
            if (dec.wr) begin
               if (dn_busy || lat_valid) n_retry = 1'b1;
               else begin n_claim = 1'b1; n_fwd = 1'b1; end
            end else if (rd_match && dn_rdata_ready) begin
               n_claim = 1'b1;
               n_clear = 1'b1;
            end else begin
               n_retry = 1'b1;
               if (!lat_valid && !dn_busy && dn_owned) begin
                  n_fwd   = 1'b1;
                  n_latch = 1'b1;
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_claim   <= 1'b0;
         tgt_retry   <= 1'b0;
         cfg_strobe  <= 1'b0;
         fwd_req     <= 1'b0;
         mem_claim_q <= 1'b0;
         fwd_write   <= 1'b0;
         fwd_addr    <= '0;
         fwd_be      <= '0;
         fwd_words   <= '0;
         lat_valid   <= 1'b0;
         lat_addr    <= '0;
         lat_cmd     <= '0;
      end else begin
         tgt_claim   <= n_claim;
         tgt_retry   <= n_retry;
         cfg_strobe  <= n_cfg;
         fwd_req     <= n_fwd;
         mem_claim_q <= n_claim && !n_cfg;
         if (n_claim || n_fwd) fwd_words <= lim;
         if (n_fwd) begin
            fwd_write <= dec.wr;
            fwd_addr  <= addr;
            fwd_be    <= be;
         end
         if (n_latch) begin
            lat_valid <= 1'b1;
            lat_addr  <= addr;
            lat_cmd   <= cmd;
         end else if (n_clear) begin
            lat_valid <= 1'b0;
         end
      end
   end

   AST_CLAIM_RETRY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(tgt_claim && tgt_retry)); // R5
   AST_IO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && (cmd == CMD_IO_RD || cmd == CMD_IO_WR))
      |=> (!tgt_claim && !tgt_retry && !fwd_req)); // R1
   AST_CFG_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_strobe |-> (tgt_claim && !fwd_req)); // R3
   AST_RD_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && dec.mem_hit && !dec.wr && (dn_busy || !dn_owned) && !rd_match)
      |=> (tgt_retry && !fwd_req)); // R5
   AST_FWD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_req |-> (fwd_addr == $past(addr) && fwd_be == $past(be))); // R9
endmodule

// File: tb/pci_fwd_target_tb_top.sv
module pci_fwd_target_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        addr_valid = 1'b0;
   logic [3:0]  cmd = '0;
   logic [31:0] addr = '0;
   logic [3:0]  be = '0;
   logic        idsel = 1'b0;
   logic [15:0] slot_en = 16'h0009;
   logic [1:0]  cls_code = 2'b01;
   logic        dn_busy = 1'b0;
   logic        dn_owned = 1'b1;
   logic        dn_rdata_ready = 1'b0;
   logic        data_beat = 1'b0;
   logic        tgt_claim, tgt_retry, tgt_disc, cfg_strobe, fwd_req, fwd_write;
   logic [31:0] fwd_addr;
   logic [3:0]  fwd_be;
   logic [4:0]  fwd_words;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   pci_fwd_target dut_i (
      .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .cmd(cmd), .addr(addr),
      .be(be), .idsel(idsel), .slot_en(slot_en), .cls_code(cls_code),
      .dn_busy(dn_busy), .dn_owned(dn_owned), .dn_rdata_ready(dn_rdata_ready),
      .data_beat(data_beat), .tgt_claim(tgt_claim), .tgt_retry(tgt_retry),
      .tgt_disc(tgt_disc), .cfg_strobe(cfg_strobe), .fwd_req(fwd_req),
      .fwd_write(fwd_write), .fwd_addr(fwd_addr), .fwd_be(fwd_be),
      .fwd_words(fwd_words));

   // {cmd, addr, idsel, busy, owned, claim, retry, cfg, fwd}; slot_en = 0009
   localparam int NV = 12;
   localparam logic [42:0] VEC [NV] = '{
      {4'h7, 32'hF3000010, 1'b0, 1'b0, 1'b1, 4'b1001},  // R4 R2 enabled slot 3
      {4'h7, 32'hF1000000, 1'b0, 1'b0, 1'b1, 4'b0000},  // R2 slot 1 disabled
      {4'h7, 32'h83000000, 1'b0, 1'b0, 1'b1, 4'b0000},  // R2 top nibble not F
      {4'h3, 32'hF3000000, 1'b0, 1'b0, 1'b1, 4'b0000},  // R1 I/O write
      {4'h2, 32'hF0000000, 1'b0, 1'b0, 1'b1, 4'b0000},  // R1 I/O read
      {4'hA, 32'h00000010, 1'b1, 1'b0, 1'b1, 4'b1010},  // R3 type 0 to self
      {4'hB, 32'h00000010, 1'b0, 1'b0, 1'b1, 4'b0000},  // R3 no idsel
      {4'hA, 32'h00000011, 1'b1, 1'b0, 1'b1, 4'b0000},  // R3 type 1
      {4'h6, 32'hF0000000, 1'b0, 1'b1, 1'b1, 4'b0100},  // R5 busy
      {4'h6, 32'hF0000000, 1'b0, 1'b0, 1'b0, 4'b0100},  // R5 not owned
      {4'h7, 32'hF0000004, 1'b0, 1'b1, 1'b1, 4'b0100},  // R4 busy write
      {4'hF, 32'hF0000040, 1'b0, 1'b0, 1'b1, 4'b1001}   // R4 write-invalidate
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive one address phase; returns after the response edge
   task automatic phase(input logic [3:0] c, input logic [31:0] a, input logic [3:0] b,
                        input logic sel);
      @(negedge clk);
      cmd = c; addr = a; be = b; idsel = sel; addr_valid = 1'b1;
      @(negedge clk);
      addr_valid = 1'b0;
   endtask

   task automatic resp(input string req, input logic [3:0] exp);
      check(req, {28'd0, tgt_claim, tgt_retry, cfg_strobe, fwd_req}, {28'd0, exp});
   endtask

   task automatic beat;
      @(negedge clk); data_beat = 1'b1;
      @(negedge clk); data_beat = 1'b0;
   endtask

   // after a claim: count beats until disconnect, expect it on beat number lim
   task automatic burst_check(input string req, input int lim);
      @(negedge clk);
      for (int k = 1; k <= lim; k++) begin
         check(req, {31'd0, tgt_disc}, {31'd0, (k == lim)});
         beat();
      end
      check(req, {31'd0, tgt_disc}, 32'd0);
   endtask

   task automatic do_reset;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      // R10 reset state
      check("R10", {27'd0, tgt_claim, tgt_retry, cfg_strobe, fwd_req, tgt_disc}, 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         dn_busy = VEC[i][5]; dn_owned = VEC[i][4];
         phase(VEC[i][42:39], VEC[i][38:7], 4'hF, VEC[i][6]);
         resp($sformatf("R1-table vec %0d", i), VEC[i][3:0]);
      end
      dn_busy = 1'b0; dn_owned = 1'b1;

      // R9 address and byte lanes forwarded unchanged
      phase(4'h7, 32'hF3ABCDE4, 4'b0101, 1'b0);
      check("R9 addr", fwd_addr, 32'hF3ABCDE4);
      check("R9 be", {28'd0, fwd_be}, 32'h5);
      check("R4 write flag", {31'd0, fwd_write}, 32'd1);

      // R8 ordinary burst: 2 words
      check("R8 words", {27'd0, fwd_words}, 32'd2);
      burst_check("R8 ordinary", 2);

      // R8 cache-line write with each line code
      cls_code = 2'b00;
      phase(4'hF, 32'hF0000100, 4'hF, 1'b0);
      check("R8 cls00", {27'd0, fwd_words}, 32'd4);
      burst_check("R8 line4", 4);
      cls_code = 2'b10;
      phase(4'hF, 32'hF0000200, 4'hF, 1'b0);
      check("R8 cls10", {27'd0, fwd_words}, 32'd16);
      cls_code = 2'b11;
      phase(4'hF, 32'hF0000300, 4'hF, 1'b0);
      check("R8 cls11", {27'd0, fwd_words}, 32'd2);
      cls_code = 2'b01;
      phase(4'hF, 32'hF0000400, 4'hF, 1'b0);
      check("R8 cls01", {27'd0, fwd_words}, 32'd8);
      burst_check("R8 line8", 8);

      // R6 read launch
      phase(4'h6, 32'hF3000020, 4'h3, 1'b0);
      resp("R6 launch", 4'b0101);
      check("R6 read flag", {31'd0, fwd_write}, 32'd0);
      check("R6 addr", fwd_addr, 32'hF3000020);
      // R7 different read while latched
      dn_rdata_ready = 1'b1;
      phase(4'h6, 32'hF3000024, 4'h3, 1'b0);
      resp("R7 other read", 4'b0100);
      // R4 write while read latched
      phase(4'h7, 32'hF3000040, 4'hF, 1'b0);
      resp("R4 write vs latch", 4'b0100);
      // R5 repeat before data ready
      dn_rdata_ready = 1'b0;
      phase(4'h6, 32'hF3000020, 4'h3, 1'b0);
      resp("R5 early repeat", 4'b0100);
      // R7 completing repeat
      dn_rdata_ready = 1'b1;
      phase(4'h6, 32'hF3000020, 4'h3, 1'b0);
      resp("R7 complete", 4'b1000);
      burst_check("R8 read burst", 2);
      // R7 latch cleared: same read launches again
      dn_rdata_ready = 1'b0;
      phase(4'h6, 32'hF3000020, 4'h3, 1'b0);
      resp("R7 relaunch", 4'b0101);

      // R10 reset clears latch: a write is then claimed
      do_reset();
      check("R10 post reset", {28'd0, tgt_claim, tgt_retry, cfg_strobe, fwd_req}, 32'd0);
      phase(4'h7, 32'hF0000008, 4'hF, 1'b0);
      resp("R10 latch cleared", 4'b1001);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule